// File: doc/BRIEF.md
# Two-speed clock start-up controller

This controller picks the system clock source for a small processor core. Three sources are available: a fast internal oscillator, an external oscillator and a low-speed secondary oscillator. The analog oscillators and the glitch-free clock multiplexer sit outside the block. Edges of the external oscillator reach the block as a one-cycle enable, and all logic runs on one clock.

When the external oscillator is a crystal type, a start-up timer counts its cycles before that source is trusted. With two-speed start-up enabled, the core runs on the internal oscillator while the timer counts. It moves to the external oscillator as soon as the count completes. A software select field can force the internal or the secondary source. An automatic change made by the start-up logic never rewrites that field. A status flag and the source output show what is actually running. Each change of source comes with a one-cycle pulse for the downstream multiplexer.

Top module: `twospeed_clk_ctrl`

## Requirements
- R1: After reset, clk_src is 00 (internal), sel_field is 00, xtal_stable is 0 and src_switch is 0.
- R2: sel_field takes sel_wdata in the cycle sel_wr is high and changes at no other time; automatic source changes never alter it.
- R3: When sel_field[1] is 1, clk_src becomes 00 (internal) one cycle after the field takes that value.
- R4: When sel_field is 01, clk_src becomes 10 (secondary) one cycle after sec_ready is seen high; while sec_ready is low, the current source stays.
- R5: When sel_field is 00 and osc_mode is 3 to 7 (direct external clock), clk_src is 01 (external) with no wait, and xtal_stable stays 0.
- R6: When osc_mode is 0, 1 or 2 (LP, XT, HS crystal types), the timer counts ext_edge pulses. xtal_stable sets on the edge that completes OST_CYCLES (default 1024) counts. With sw_en=1 and sel_field=00, clk_src is 00 until then and 01 from the next cycle.
- R7: In a crystal mode with sw_en=0 and sel_field=00, clk_src is 01 (external) from the first cycle.
- R8: The start-up timer counts no ext_edge before the first pwrup_done pulse after reset.
- R9: sleep_req clears the count and xtal_stable, and it wins over an ext_edge that would complete the count in the same cycle. No edge is counted while asleep. After wake, counting restarts from zero.
- R10: src_switch is high for exactly the first cycle in which clk_src shows a new value, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_mode | input | 3 | Configured oscillator mode: 0 LP, 1 XT, 2 HS, 3-7 direct external |
| sw_en | input | 1 | Internal/external switchover enable |
| sel_wr | input | 1 | Write strobe for the select field |
| sel_wdata | input | 2 | Select value: 00 config, 01 secondary, 1x internal |
| sec_ready | input | 1 | Secondary oscillator ready |
| pwrup_done | input | 1 | Pulse: power-up delay has expired |
| sleep_req | input | 1 | Pulse: entering sleep |
| wake | input | 1 | Pulse: wake from sleep |
| ext_edge | input | 1 | One pulse per external oscillator cycle |
| clk_src | output | 2 | Active source: 00 internal, 01 external, 10 secondary |
| sel_field | output | 2 | Software select field |
| xtal_stable | output | 1 | Start-up timer has completed |
| src_switch | output | 1 | One-cycle pulse on each source change |

## Verification
The clash that matters is a sleep entry that lands in the same cycle as the external edge that would complete the start-up count. The bench drives exactly OST_CYCLES-1 edges after a wake and then raises sleep_req together with the final edge. It expects xtal_stable to stay clear and a full new count to be needed after the next wake. Random runs also let select writes, ready changes and count completion meet in one cycle, and a bench model judges each cycle.

// File: rtl/twospeed_clk_ctrl.sv
module twospeed_clk_ctrl #(
  parameter int OST_CYCLES = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] osc_mode,
  input  logic       sw_en,
  input  logic       sel_wr,
  input  logic [1:0] sel_wdata,
  input  logic       sec_ready,
  input  logic       pwrup_done,
  input  logic       sleep_req,
  input  logic       wake,
  input  logic       ext_edge,
  output logic [1:0] clk_src,
  output logic [1:0] sel_field,
  output logic       xtal_stable,
  output logic       src_switch
);
  localparam int CW = $clog2(OST_CYCLES + 1);
  localparam logic [1:0] SRC_INT = 2'b00;
  localparam logic [1:0] SRC_EXT = 2'b01;
  localparam logic [1:0] SRC_SEC = 2'b10;

  logic [CW-1:0] cnt;
  logic [1:0]    sel_q, src_q, tgt;
  logic          done_q, started, asleep, pulse_q;

  wire crystal  = (osc_mode <= 3'd2);
  wire counting = started & ~asleep & crystal & ~done_q;
  wire last_one = (cnt == CW'(OST_CYCLES - 1));

  always_comb begin
    tgt = src_q;
    if (sel_q[1])
      tgt = SRC_INT;
    else if (sel_q[0]) begin
      if (sec_ready) tgt = SRC_SEC;
    end else if (!crystal || done_q || !sw_en)
      tgt = SRC_EXT;
    else
      tgt = SRC_INT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q   <= 2'b00;
      src_q   <= SRC_INT;
      pulse_q <= 1'b0;
      cnt     <= '0;
      done_q  <= 1'b0;
      started <= 1'b0;
      asleep  <= 1'b0;
    end else begin
      if (sel_wr) sel_q <= sel_wdata;
      if (pwrup_done) started <= 1'b1;
      if (sleep_req) begin
        asleep <= 1'b1;
        cnt    <= '0;
        done_q <= 1'b0;
      end else begin
        if (wake) asleep <= 1'b0;
        if (counting && ext_edge) begin
          if (last_one) begin
            cnt    <= '0;
            done_q <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
      src_q   <= tgt;
      pulse_q <= (tgt != src_q);
    end
  end

  assign clk_src     = src_q;
  assign sel_field   = sel_q;
  assign xtal_stable = done_q;
  assign src_switch  = pulse_q;
endmodule

module twospeed_clk_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] osc_mode,
  input logic       sel_wr,
  input logic       sec_ready,
  input logic       sleep_req,
  input logic [1:0] clk_src,
  input logic [1:0] sel_field,
  input logic       xtal_stable,
  input logic       src_switch
);
  p_sel_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_wr |=> $stable(sel_field));
  p_int_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_field[1] |=> clk_src == 2'b00);
  p_sec_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_src == 2'b10 && $past(clk_src) != 2'b10) |-> $past(sec_ready));
  p_direct_ext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_field == 2'b00 && osc_mode > 3'd2) |=> clk_src == 2'b01);
  p_stable_xtal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xtal_stable) |-> $past(osc_mode) <= 3'd2);
  p_sleep_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req |=> !xtal_stable);
  p_pulse_on_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_src != $past(clk_src)) |-> src_switch);
  p_pulse_only_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
    src_switch |-> (clk_src != $past(clk_src)));
endmodule

bind twospeed_clk_ctrl twospeed_clk_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .osc_mode(osc_mode), .sel_wr(sel_wr),
  .sec_ready(sec_ready), .sleep_req(sleep_req), .clk_src(clk_src),
  .sel_field(sel_field), .xtal_stable(xtal_stable), .src_switch(src_switch)
);

// File: tb/sim_twospeed_clk_ctrl.sv
`timescale 1ns/1ps
module sim_twospeed_clk_ctrl;
  localparam int N = 1024;

  logic clk = 0, rst_n = 0;
  logic [2:0] osc_mode = 3'd0;
  logic sw_en = 1, sel_wr = 0, sec_ready = 0, pwrup_done = 0;
  logic sleep_req = 0, wake = 0, ext_edge = 0;
  logic [1:0] sel_wdata = 2'b00;
  logic [1:0] clk_src, sel_field;
  logic xtal_stable, src_switch;

  int tests = 0, fails = 0;
  bit model_on = 0;

  always #4 clk = ~clk;

  twospeed_clk_ctrl #(.OST_CYCLES(N)) u0 (
    .clk(clk), .rst_n(rst_n), .osc_mode(osc_mode), .sw_en(sw_en),
    .sel_wr(sel_wr), .sel_wdata(sel_wdata), .sec_ready(sec_ready),
    .pwrup_done(pwrup_done), .sleep_req(sleep_req), .wake(wake),
    .ext_edge(ext_edge), .clk_src(clk_src), .sel_field(sel_field),
    .xtal_stable(xtal_stable), .src_switch(src_switch));

  // Behavioural expectation built from the requirements
  logic [1:0] m_sel, m_src;
  logic m_done, m_started, m_asleep, m_pulse;
  int m_cnt;

  function automatic logic [1:0] want_src(logic [1:0] sel, logic [1:0] cur,
      logic [2:0] mode, logic en, logic rdy, logic done);
    if (sel[1]) return 2'b00;
    if (sel[0]) return rdy ? 2'b10 : cur;
    if (mode > 3'd2 || done || !en) return 2'b01;
    return 2'b00;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sel <= 0; m_src <= 0; m_done <= 0; m_started <= 0;
      m_asleep <= 0; m_pulse <= 0; m_cnt <= 0;
    end else begin
      logic [1:0] t;
      t = want_src(m_sel, m_src, osc_mode, sw_en, sec_ready, m_done);
      m_src <= t;
      m_pulse <= (t != m_src);
      if (sel_wr) m_sel <= sel_wdata;
      if (pwrup_done) m_started <= 1;
      if (sleep_req) begin
        m_asleep <= 1; m_cnt <= 0; m_done <= 0;
      end else begin
        if (wake) m_asleep <= 0;
        if (ext_edge && m_started && !m_asleep && osc_mode <= 3'd2 && !m_done) begin
          if (m_cnt == N - 1) begin m_cnt <= 0; m_done <= 1; end
          else m_cnt <= m_cnt + 1;
        end
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(logic [2:0] mode, logic en);
    osc_mode = mode; sw_en = en; rst_n = 0;
    sel_wr = 0; sec_ready = 0; pwrup_done = 0; sleep_req = 0; wake = 0; ext_edge = 0;
    cyc(2);
    rst_n = 1;
  endtask

  task automatic write_sel(logic [1:0] v);
    sel_wr = 1; sel_wdata = v; cyc(); sel_wr = 0;
  endtask

  task automatic pulse_pwrup();
    pwrup_done = 1; cyc(); pwrup_done = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R1 reset state, LP two-speed
    do_reset(3'd0, 1);
    check("R1 src", clk_src, 0); check("R1 sel", sel_field, 0);
    check("R1 stable", xtal_stable, 0); check("R1 pulse", src_switch, 0);
    // R8: edges before power-up are not counted
    ext_edge = 1; cyc(1100); ext_edge = 0;
    check("R8 stable", xtal_stable, 0); check("R8 src", clk_src, 0);
    // R6 count to N
    pulse_pwrup();
    ext_edge = 1; cyc(N - 1);
    check("R6 stable early", xtal_stable, 0); check("R6 src int", clk_src, 0);
    cyc();
    ext_edge = 0;
    check("R6 stable", xtal_stable, 1); check("R6 src still int", clk_src, 0);
    cyc();
    check("R6 src ext", clk_src, 1); check("R10 pulse", src_switch, 1);
    cyc();
    check("R10 pulse one cycle", src_switch, 0);
    // R4 secondary needs ready
    write_sel(2'b01); cyc(3);
    check("R4 hold", clk_src, 1); check("R2 sel", sel_field, 1);
    check("R10 no pulse", src_switch, 0);
    sec_ready = 1; cyc();
    check("R4 sec", clk_src, 2); check("R10 pulse sec", src_switch, 1);
    // R3 internal
    write_sel(2'b10); cyc();
    check("R3 int", clk_src, 0); check("R2 sel int", sel_field, 2);
    write_sel(2'b00); cyc();
    check("R2 sel back", sel_field, 0); check("R6 back ext", clk_src, 1);
    check("R2 stable kept", xtal_stable, 1);
    // R9 sleep clears, abort on final edge
    sleep_req = 1; cyc(); sleep_req = 0;
    check("R9 cleared", xtal_stable, 0); check("R2 sel after sleep", sel_field, 0);
    ext_edge = 1; cyc(10); ext_edge = 0;
    check("R9 frozen asleep", xtal_stable, 0); check("R9 src int", clk_src, 0);
    wake = 1; cyc(); wake = 0;
    ext_edge = 1; cyc(N - 1);
    check("R9 count pre", xtal_stable, 0);
    sleep_req = 1; cyc(); sleep_req = 0; ext_edge = 0;
    check("R9 sleep wins", xtal_stable, 0);
    wake = 1; cyc(); wake = 0;
    ext_edge = 1; cyc(N - 1);
    check("R9 restart from zero", xtal_stable, 0);
    cyc(); ext_edge = 0;
    check("R9 completes", xtal_stable, 1);
    // R7 crystal without switchover
    do_reset(3'd1, 0);
    check("R1 src after reset", clk_src, 0);
    cyc();
    check("R7 ext", clk_src, 1); check("R10 pulse R7", src_switch, 1);
    // R5 direct external
    do_reset(3'd5, 1);
    cyc();
    check("R5 ext", clk_src, 1);
    pulse_pwrup(); ext_edge = 1; cyc(N + 50); ext_edge = 0;
    check("R5 no stable", xtal_stable, 0); check("R5 still ext", clk_src, 1);

    // random phase against bench model
    void'($urandom(32'd1234));
    do_reset(3'd0, 1);
    model_on = 1;
    for (int i = 0; i < 20000; i++) begin
      check("R3 src", clk_src, m_src);
      check("R2 sel", sel_field, m_sel);
      check("R6 stable", xtal_stable, m_done);
      check("R10 pulse", src_switch, m_pulse);
      sel_wr = ($urandom_range(0, 59) == 0);
      sel_wdata = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 79) == 0) sec_ready = ~sec_ready;
      if ($urandom_range(0, 1999) == 0) osc_mode = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 999) == 0) sw_en = ~sw_en;
      sleep_req = ($urandom_range(0, 2999) == 0);
      wake = ($urandom_range(0, 49) == 0);
      pwrup_done = ($urandom_range(0, 199) == 0);
      ext_edge = ($urandom_range(0, 9) < 8);
      cyc();
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule